// File: doc/BRIEF.md
# CAN Frame Acknowledge and CRC Error Signaling

This block sits beside a CAN frame decoder and handles the end of every frame. It runs whether or not the node wants the frame's content. It builds the 15-bit frame CRC over the bits the decoder marks as covered. It collects the CRC field as it arrives on the bus. At the acknowledge slot it decides what the node drives onto its transmit line.

In the receiver role, a matching CRC makes the node drive a dominant acknowledge for the slot. A mismatch leaves the slot recessive, raises a one-clock drop pulse for the frame, and then sends a six-bit dominant error flag. In the transmitter role the block never drives the slot. It samples the slot instead, and a recessive value raises a one-clock resend request.

The bus bits arrive as a stream qualified by `bit_stb`, which is a one-clock valid with no ready. A bus bit cannot be held back, so there is no back-pressure: every strobe is consumed in the clock it is asserted. The marker inputs and `bus_rx` are read only on that clock.

Top module: `canbus_ack_guard`

## Requirements
- R1: While reset is asserted and after it is released, `bus_tx` is 1 (recessive), and `resend_req` and `frame_drop` are 0.
- R2: The computed CRC uses the polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (0x4599). It starts at zero, and on each strobe with `crc_span`=1 it takes `bus_rx` with feedback `bus_rx` XOR the register MSB. The received CRC is shifted in most significant bit first on strobes with `crc_field`=1.
- R3: In the receiver role (`node_is_tx`=0 latched at frame start), a strobe with `ack_next`=1 and matching CRCs sets `bus_tx` to 0. `bus_tx` returns to 1 at the next strobe.
- R4: In the receiver role, a strobe with `ack_next`=1 and differing CRCs leaves `bus_tx` at 1. On the clock after that strobe, `frame_drop` pulses.
- R5: After a mismatch, `bus_tx` becomes 0 at the strobe that ends the acknowledge slot. It stays 0 for six bit periods and is 1 again after the sixth strobe of the flag.
- R6: In the transmitter role, `bus_tx` stays 1 throughout the frame and `frame_drop` never pulses.
- R7: In the transmitter role, at the strobe that ends the acknowledge slot, `bus_rx`=1 produces a `resend_req` pulse. `bus_rx`=0 produces none.
- R8: A strobe with `frame_start`=1 clears both CRC registers, latches the role from `node_is_tx`, and ends any error flag in progress: `bus_tx` is 1 after that strobe.
- R9: `resend_req` and `frame_drop` are high for exactly one clock.
- R10: `bus_tx` changes only on clocks where `bit_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-clock valid for the sampled bus bit |
| bus_rx | input | 1 | Sampled bus level (0 dominant) |
| frame_start | input | 1 | Strobed bit begins a new frame |
| crc_span | input | 1 | Strobed bit is covered by the CRC |
| crc_field | input | 1 | Strobed bit belongs to the received CRC |
| ack_next | input | 1 | The bit period after this strobe is the acknowledge slot |
| node_is_tx | input | 1 | Node is the frame's sender (latched at frame start) |
| bus_tx | output | 1 | Transmit line (idles 1) |
| resend_req | output | 1 | One-clock pulse: sent frame was not acknowledged |
| frame_drop | output | 1 | One-clock pulse: received frame failed its CRC |

## Verification
The hardest state to reach is a frame start that lands in the middle of a six-bit error flag. This needs a receiver-role frame whose CRC field is wrong, followed by a restart before the flag has run out. The stimulus corrupts one random bit of a correct CRC field, lets two flag bits pass, then strobes a frame start. A clean frame follows to show that both CRC registers were cleared. Random frames of varying length, role and acknowledge state surround these directed cases.

// File: rtl/canack_pkg.sv
package canack_pkg;
  localparam int unsigned CRC_W     = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int unsigned FLAG_BITS = 6;
endpackage

// File: rtl/canack_crc.sv
module canack_crc #(
  parameter int unsigned W = 15,
  parameter logic [W-1:0] POLY = 15'h4599
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic clr,
  input  logic cov,
  input  logic fld,
  input  logic din,
  output logic match
);
  logic [W-1:0] calc_q, rcvd_q, calc_nxt, shifted;
  logic         fb;

  always_comb begin
    fb       = din ^ calc_q[W-1];
    shifted  = {calc_q[W-2:0], 1'b0};
    calc_nxt = fb ? (shifted ^ POLY) : shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calc_q <= '0;
      rcvd_q <= '0;
    end else if (stb) begin
      if (clr) begin
        calc_q <= '0;
        rcvd_q <= '0;
      end else begin
        if (cov) calc_q <= calc_nxt;
        if (fld) rcvd_q <= {rcvd_q[W-2:0], din};
      end
    end
  end

  assign match = (calc_q == rcvd_q);

  // R2
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(calc_q) && $stable(rcvd_q));

  // R8
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && clr) |=> (calc_q == '0) && (rcvd_q == '0));
endmodule

// File: rtl/canack_seq.sv
module canack_seq #(
  parameter int unsigned FLAG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic sof,
  input  logic role_in,
  input  logic slot_mark,
  input  logic din,
  input  logic match,
  output logic tx_line,
  output logic resend,
  output logic discard
);
  localparam int unsigned CW = $clog2(FLAG + 1);

  logic          role_tx, slot_pend, err_pend;
  logic [CW-1:0] err_cnt;
  logic          tx_q, rs_q, dc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role_tx   <= 1'b0;
      slot_pend <= 1'b0;
      err_pend  <= 1'b0;
      err_cnt   <= '0;
      tx_q      <= 1'b1;
      rs_q      <= 1'b0;
      dc_q      <= 1'b0;
    end else begin
      rs_q <= 1'b0;
      dc_q <= 1'b0;
      if (stb) begin
        if (sof) begin
          role_tx   <= role_in;
          slot_pend <= 1'b0;
          err_pend  <= 1'b0;
          err_cnt   <= '0;
          tx_q      <= 1'b1;
        end else begin
          slot_pend <= slot_mark;
          if (slot_mark) begin
            if (!role_tx) begin
              if (match) begin
                tx_q <= 1'b0;
              end else begin
                err_pend <= 1'b1;
                dc_q     <= 1'b1;
              end
            end
          end else if (slot_pend) begin
            if (role_tx && din) rs_q <= 1'b1;
            if (err_pend) begin
              err_pend <= 1'b0;
              err_cnt  <= CW'(1);
              tx_q     <= 1'b0;
            end else begin
              tx_q <= 1'b1;
            end
          end else if (err_cnt != '0) begin
            if (err_cnt == CW'(FLAG)) begin
              err_cnt <= '0;
              tx_q    <= 1'b1;
            end else begin
              err_cnt <= err_cnt + CW'(1);
            end
          end
        end
      end
    end
  end

  assign tx_line = tx_q;
  assign resend  = rs_q;
  assign discard = dc_q;

  // R10
  tx_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(tx_q));

  // R9
  resend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |=> !rs_q);

  // R9
  drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_q |=> !dc_q);

  // R6
  tx_role_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    role_tx |-> (tx_q && !dc_q));

  // R7
  resend_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |-> role_tx);

  // R5
  flag_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= CW'(FLAG));
endmodule

// File: rtl/canbus_ack_guard.sv
module canbus_ack_guard
  import canack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bus_rx,
  input  logic frame_start,
  input  logic crc_span,
  input  logic crc_field,
  input  logic ack_next,
  input  logic node_is_tx,
  output logic bus_tx,
  output logic resend_req,
  output logic frame_drop
);
  logic crc_ok;

  canack_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (bit_stb),
    .clr   (frame_start),
    .cov   (crc_span),
    .fld   (crc_field),
    .din   (bus_rx),
    .match (crc_ok)
  );

  canack_seq #(.FLAG(FLAG_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (bit_stb),
    .sof       (frame_start),
    .role_in   (node_is_tx),
    .slot_mark (ack_next),
    .din       (bus_rx),
    .match     (crc_ok),
    .tx_line   (bus_tx),
    .resend    (resend_req),
    .discard   (frame_drop)
  );

  // R1
  idle_line_chk: assert property (@(posedge clk) !rst_n |=> bus_tx && !resend_req && !frame_drop);
endmodule

// File: tb/sim_canbus_ack_guard.sv
module sim_canbus_ack_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, bus_rx = 1'b1, frame_start = 1'b0;
  logic crc_span = 1'b0, crc_field = 1'b0, ack_next = 1'b0, node_is_tx = 1'b0;
  logic bus_tx, resend_req, frame_drop;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  logic obs_tx, obs_rs, obs_dc;

  always #5 clk = ~clk;

  canbus_ack_guard u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bus_rx(bus_rx),
    .frame_start(frame_start), .crc_span(crc_span), .crc_field(crc_field),
    .ack_next(ack_next), .node_is_tx(node_is_tx), .bus_tx(bus_tx),
    .resend_req(resend_req), .frame_drop(frame_drop)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] ref_crc(logic [127:0] pay, int n);
    logic [14:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb = pay[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    return c;
  endfunction

  task automatic send(logic b, logic s, logic cov, logic fld, logic ak);
    @(negedge clk);
    bus_rx = b; frame_start = s; crc_span = cov; crc_field = fld; ack_next = ak;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0; frame_start = 1'b0; crc_span = 1'b0; crc_field = 1'b0; ack_next = 1'b0;
    obs_tx = bus_tx; obs_rs = resend_req; obs_dc = frame_drop;
    @(negedge clk);
    if (obs_rs || obs_dc) chk("R9 pulse width", int'(resend_req | frame_drop), 0);
    chk("R10 line held between strobes", int'(bus_tx), int'(obs_tx));
  endtask

  task automatic head(int n, logic [127:0] pay, bit txr, bit bad);
    logic [14:0] c;
    node_is_tx = txr;
    send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) send(pay[i], 1'b0, 1'b1, 1'b0, 1'b0);
    c = ref_crc(pay, n);
    if (bad) c = c ^ (15'd1 << ($urandom % 15));
    for (int i = 14; i >= 0; i--) send(c[i], 1'b0, 1'b0, 1'b1, 1'b0);
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(txr ? "R6 no ack in tx role" : (bad ? "R4 slot recessive" : "R2/R3 ack dominant"),
        int'(obs_tx), (!txr && !bad) ? 0 : 1);
    chk(txr ? "R6 no drop in tx role" : "R4 drop pulse", int'(obs_dc), (!txr && bad) ? 1 : 0);
  endtask

  task automatic frame(int n, logic [127:0] pay, bit txr, bit bad, bit ackd);
    head(n, pay, txr, bad);
    send(txr ? ~ackd : obs_tx, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 resend", int'(obs_rs), (txr && !ackd) ? 1 : 0);
    chk(txr ? "R6 line after slot" : (bad ? "R5 flag start" : "R3 ack released"),
        int'(obs_tx), (!txr && bad) ? 0 : 1);
    for (int k = 1; k <= 6; k++) begin
      send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(txr ? "R6 line in eof" : "R5 flag bit", int'(obs_tx), (!txr && bad && k <= 5) ? 0 : 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 tx idle in reset", int'(bus_tx), 1);
    chk("R1 pulses low in reset", int'(resend_req | frame_drop), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx idle after reset", int'(bus_tx), 1);

    frame(11, 128'h5A3, 1'b0, 1'b0, 1'b0);
    frame(11, 128'h5A3, 1'b0, 1'b1, 1'b0);
    frame(30, 128'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);
    frame(30, 128'hDEAD_BEEF, 1'b1, 1'b0, 1'b1);
    frame(30, 128'hDEAD_BEEF, 1'b1, 1'b1, 1'b1);

    head(20, 128'hF0F0F, 1'b0, 1'b1);
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 flag running", int'(obs_tx), 0);
    node_is_tx = 1'b0;
    send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 start aborts flag", int'(obs_tx), 1);
    send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 flag stays off", int'(obs_tx), 1);
    frame(17, 128'h1_2345, 1'b0, 1'b0, 1'b0);

    for (int f = 0; f < 40; f++) begin
      logic [127:0] p = {$urandom, $urandom, $urandom, $urandom};
      frame(1 + int'($urandom % 100), p, bit'($urandom % 2), bit'($urandom % 3 == 0),
            bit'($urandom % 2));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule